// File: doc/BRIEF.md
# Burst-Capable Synchronous SRAM Access Unit

This block is the command and address front end of a synchronous burst SRAM, together with a behavioural storage array. Every rising clock edge it samples two chip enables, two address strobes, a burst step input, per-lane write enables, a byte-write qualifier, a global write enable, the address and the write data. From these it decides whether the cycle starts an access, continues a burst or does nothing. It then either writes the selected 9-bit lanes of one word or reads one word back.

A strobe loads a base address. While a burst is open, each asserted step input moves a 2-bit counter over the two lowest address bits. A mode pin selects linear (add one, wrap at four) or interleaved (XOR with a count) order. Bursting is optional, because either strobe may load a fresh address on any cycle. The word width is set by the lane count: two lanes give 18 bits and four lanes give 36 bits.

Read results leave on a valid-qualified output one cycle after the access cycle. There is no ready input. The output stage must take every word in the cycle it is flagged, because the array cannot stall.

Top module: `sram_burst_unit`

## Requirements
- R1: While reset is held, `rd_valid` is 0.
- R2: A cycle in which `cs_n`=0, `cs`=1 and the controller strobe `stb_ctl_n`=0 accesses `addr`. If that access is a read, `rd_valid`=1 in the next cycle, with `rd_addr`=`addr` and `rd_data` equal to the stored word.
- R3: A strobe sampled while `cs_n`=1 or `cs`=0 performs no access and closes any open burst. Later step inputs then perform no access until the next enabled strobe.
- R4: An enabled host strobe (`stb_host_n`=0) always performs a read of `addr` and ignores every write control. When both strobes are low, the host strobe rule applies.
- R5: With no strobe, `step_n`=0 and a burst open, the counter advances by one. The unit accesses the next burst address, writing it if the write controls request a write and reading it otherwise.
- R6: With `lin_n`=0, the low two address bits of the k-th burst step are (base+k) mod 4. The upper bits stay at the base value.
- R7: With `lin_n`=1, the low two address bits of the k-th step are base XOR (k mod 4). The upper bits stay at the base value.
- R8: A cycle with both strobes high and `step_n`=1 performs no access and keeps the burst position. A step with no open burst also performs no access.
- R9: With `bytewr_n`=0 and `allwr_n`=1, lane i (bits 9i+8..9i) is written only if `lane_wr_n[i]`=0. The other lanes keep their stored value.
- R10: With `allwr_n`=0, every lane is written, whatever the values of `bytewr_n` and `lane_wr_n`.
- R11: A cycle whose write controls enable no lane (`allwr_n`=1 and either `bytewr_n`=1 or all `lane_wr_n` high) is a read.
- R12: A write access produces no `rd_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip enable, active low |
| cs | input | 1 | Chip enable, active high |
| stb_host_n | input | 1 | Host address strobe, active low, read only, has priority |
| stb_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst step, active low |
| lin_n | input | 1 | Burst order: 0 linear, 1 interleaved |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| bytewr_n | input | 1 | Byte-write qualifier, active low |
| allwr_n | input | 1 | Global write, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | LANES*9 | Write data |
| rd_valid | output | 1 | Read word present this cycle |
| rd_addr | output | ADDR_W | Address of the word read |
| rd_data | output | LANES*9 | Read word |

## Verification
The bench builds the unit with four lanes and a 6-bit address. This gives a 36-bit word, so every lane enable can be driven alone or in combination, and a 64-word array that is small enough to fill completely and track word by word. Bursts start at every low-bit offset, so both orders can be seen wrapping. Directed sequences cover strobe priority, deselect and hold, and a long mixed random phase interleaves byte-masked, global and burst writes in both orders.

// File: rtl/sram_acc_pkg.sv
package sram_acc_pkg;
  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_WRITE} op_e;

  // low two address bits of a burst step
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] cnt,
                                           input logic lin_n);
    burst_low = lin_n ? (base ^ cnt) : (base + cnt);
  endfunction
endpackage

// File: rtl/sram_lane_mask.sv
module sram_lane_mask #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             bytewr_n,
  input  logic             allwr_n,
  output logic [LANES-1:0] lane_mask,
  output logic             wr_req
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mask[i] = !allwr_n || (!bytewr_n && !lane_wr_n[i]);
  end
  assign wr_req = |lane_mask;
endmodule

// File: rtl/sram_burst_seq.sv
module sram_burst_seq
  import sram_acc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              stb_host_n,
  input  logic              stb_ctl_n,
  input  logic              step_n,
  input  logic              lin_n,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  output op_e               op,
  output logic [ADDR_W-1:0] acc_addr
);
  logic              active_q, active_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              chip_on, strobe;

  assign chip_on = !cs_n && cs;
  assign strobe  = !stb_host_n || !stb_ctl_n;

  always_comb begin
    active_d = active_q;
    base_d   = base_q;
    cnt_d    = cnt_q;
    op       = OP_NONE;
    acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, lin_n)};
    if (strobe) begin
      if (chip_on) begin
        active_d = 1'b1;
        base_d   = addr;
        cnt_d    = 2'd0;
        acc_addr = addr;
        if (!stb_host_n) op = OP_READ;
        else             op = wr_req ? OP_WRITE : OP_READ;
      end else begin
        active_d = 1'b0;
      end
    end else if (!step_n && active_q) begin
      cnt_d    = cnt_q + 2'd1;
      acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_d, lin_n)};
      op       = wr_req ? OP_WRITE : OP_READ;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= 2'd0;
    end else begin
      active_q <= active_d;
      base_q   <= base_d;
      cnt_q    <= cnt_d;
    end
  end
endmodule

// File: rtl/sram_store.sv
module sram_store #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [LANES-1:0]  lane_mask,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (we && lane_mask[i]) mem[acc_addr] <= wdata[i*LANE_W +: LANE_W];
      if (re) q <= mem[acc_addr];
    end
    assign rd_data[i*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_addr  <= '0;
    end else begin
      rd_valid <= re;
      if (re) rd_addr <= acc_addr;
    end
  end
endmodule

// File: rtl/sram_burst_unit.sv
module sram_burst_unit
  import sram_acc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  localparam int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              stb_host_n,
  input  logic              stb_ctl_n,
  input  logic              step_n,
  input  logic              lin_n,
  input  logic [LANES-1:0]  lane_wr_n,
  input  logic              bytewr_n,
  input  logic              allwr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [LANES-1:0]  lane_mask;
  logic              wr_req;
  op_e               op;
  logic [ADDR_W-1:0] acc_addr;

  sram_lane_mask #(.LANES(LANES)) u_mask (
    .lane_wr_n(lane_wr_n), .bytewr_n(bytewr_n), .allwr_n(allwr_n),
    .lane_mask(lane_mask), .wr_req(wr_req)
  );

  sram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs),
    .stb_host_n(stb_host_n), .stb_ctl_n(stb_ctl_n), .step_n(step_n),
    .lin_n(lin_n), .wr_req(wr_req), .addr(addr),
    .op(op), .acc_addr(acc_addr)
  );

  sram_store #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(op == OP_WRITE), .re(op == OP_READ),
    .lane_mask(lane_mask), .acc_addr(acc_addr), .wdata(wdata),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: rtl/sram_burst_unit_chk.sv
module sram_burst_unit_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              cs,
  input logic              stb_host_n,
  input logic              stb_ctl_n,
  input logic              step_n,
  input logic              lin_n,
  input logic              allwr_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr
);
  AST_HOST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!stb_host_n && !cs_n && cs) |=> (rd_valid && rd_addr == $past(addr))); // R4
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((!stb_host_n || !stb_ctl_n) && !(!cs_n && cs)) |=> !rd_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_host_n && stb_ctl_n && step_n) |=> !rd_valid); // R8
  AST_GLOBAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_host_n && !stb_ctl_n && !cs_n && cs && !allwr_n) |=> !rd_valid); // R12
  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(rd_valid) && $past(stb_host_n && stb_ctl_n) && !$past(lin_n))
    |-> (rd_addr[1:0] == $past(rd_addr[1:0]) + 2'd1 &&
         rd_addr[ADDR_W-1:2] == $past(rd_addr[ADDR_W-1:2]))); // R6
endmodule

bind sram_burst_unit sram_burst_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs),
  .stb_host_n(stb_host_n), .stb_ctl_n(stb_ctl_n), .step_n(step_n),
  .lin_n(lin_n), .allwr_n(allwr_n), .addr(addr),
  .rd_valid(rd_valid), .rd_addr(rd_addr)
);

// File: tb/sram_burst_unit_tb.sv
module sram_burst_unit_tb;
  localparam int A = 6;
  localparam int L = 4;
  localparam int D = L * 9;
  localparam int DEPTH = 1 << A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, cs = 1'b0, stb_host_n = 1'b1, stb_ctl_n = 1'b1;
  logic step_n = 1'b1, lin_n = 1'b1, bytewr_n = 1'b1, allwr_n = 1'b1;
  logic [L-1:0] lane_wr_n = '1;
  logic [A-1:0] addr = '0;
  logic [D-1:0] wdata = '0;
  logic rd_valid;
  logic [A-1:0] rd_addr;
  logic [D-1:0] rd_data;

  always #5 clk = ~clk;

  sram_burst_unit #(.ADDR_W(A), .LANES(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs(cs),
    .stb_host_n(stb_host_n), .stb_ctl_n(stb_ctl_n), .step_n(step_n),
    .lin_n(lin_n), .lane_wr_n(lane_wr_n), .bytewr_n(bytewr_n),
    .allwr_n(allwr_n), .addr(addr), .wdata(wdata),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  typedef struct {
    bit           v;
    logic [A-1:0] a;
    logic [D-1:0] d;
    int           req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, failures = 0;
  bit done = 0;

  // reference state
  logic [D-1:0] ref_mem [DEPTH];
  bit           m_active = 0;
  logic [A-1:0] m_base = '0;
  logic [1:0]   m_cnt = '0;

  function automatic logic [A-1:0] step_addr(logic [A-1:0] b, logic [1:0] k, logic ln);
    logic [1:0] lo;
    lo = ln ? (b[1:0] ^ k) : (b[1:0] + k);   // R7 interleaved, R6 linear
    return {b[A-1:2], lo};
  endfunction

  task automatic cyc(input bit hs, input bit ct, input bit st, input bit e1n, input bit e2,
                     input bit ln, input bit bq, input bit gq, input logic [L-1:0] lw,
                     input logic [A-1:0] a, input logic [D-1:0] d, input int req);
    bit acc, wr;
    logic [A-1:0] aa;
    logic [L-1:0] m;
    exp_t e;
    @(negedge clk);
    stb_host_n = hs; stb_ctl_n = ct; step_n = st; cs_n = e1n; cs = e2;
    lin_n = ln; bytewr_n = bq; allwr_n = gq; lane_wr_n = lw; addr = a; wdata = d;
    for (int i = 0; i < L; i++) m[i] = !gq || (!bq && !lw[i]);   // R9 R10
    acc = 0; wr = 0; aa = '0;
    if (!hs || !ct) begin
      if (!e1n && e2) begin
        m_active = 1; m_base = a; m_cnt = 0; aa = a; acc = 1;
        wr = hs && (m != '0);                                    // R4 R11
      end else m_active = 0;                                     // R3
    end else if (!st && m_active) begin
      m_cnt = m_cnt + 2'd1; aa = step_addr(m_base, m_cnt, ln); acc = 1; // R5
      wr = (m != '0);
    end
    if (acc && wr)
      for (int i = 0; i < L; i++) if (m[i]) ref_mem[aa][i*9 +: 9] = d[i*9 +: 9];
    e.v = acc && !wr; e.a = aa; e.d = ref_mem[aa]; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input int n, input int req);
    for (int i = 0; i < n; i++) cyc(1,1,1,0,1,1,1,1,'1,'0,'0,req);
  endtask

  function automatic logic [D-1:0] rnd_d();
    return {$urandom(), $urandom()};
  endfunction

  // monitor
  initial begin
    forever begin
      @(posedge clk); #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (rd_valid !== e.v || (e.v && (rd_addr !== e.a || rd_data !== e.d))) begin
          failures++;
          $display("FAIL R%0d valid=%b/%b addr=%h/%h data=%h/%h", e.req,
                   rd_valid, e.v, rd_addr, e.a, rd_data, e.d);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;                                   // R1 reset state
    if (rd_valid !== 1'b0) begin
      failures++; $display("FAIL R1 valid=%b/0", rd_valid);
    end
    @(negedge clk); rst_n = 1'b1;

    // fill the whole array with global writes through the controller strobe (R10)
    for (int i = 0; i < DEPTH; i++)
      cyc(1,0,1,0,1,1,1,0,'1,A'(i),rnd_d(),10);
    // single reads (R2), host strobe with write controls asserted (R4)
    cyc(1,0,1,0,1,1,1,1,'1,6'h05,'0,2);
    cyc(1,0,1,0,1,1,1,1,'1,6'h3a,'0,2);
    cyc(0,1,1,0,1,1,0,0,'0,6'h11,rnd_d(),4);
    cyc(0,0,1,0,1,1,1,0,'1,6'h12,rnd_d(),4);
    cyc(1,0,1,0,1,1,1,1,'1,6'h11,'0,4);
    cyc(1,0,1,0,1,1,1,1,'1,6'h12,'0,4);
    // linear burst from low bits 2, wrapping (R6)
    cyc(1,0,1,0,1,0,1,1,'1,6'h0e,'0,6);
    for (int k = 0; k < 5; k++) cyc(1,1,0,0,1,0,1,1,'1,'0,'0,6);
    // interleaved bursts from every offset (R7)
    for (int b = 0; b < 4; b++) begin
      cyc(0,1,1,0,1,1,1,1,'1,A'(8'h20 + b),'0,7);
      for (int k = 0; k < 4; k++) cyc(1,1,0,0,1,1,1,1,'1,'0,'0,7);
    end
    // burst write: byte lanes 0 and 2 on the strobe, global on the steps (R5 R9)
    cyc(1,0,1,0,1,1,0,1,4'b1010,6'h31,rnd_d(),9);
    for (int k = 0; k < 3; k++) cyc(1,1,0,0,1,1,1,0,'1,'0,rnd_d(),5);
    cyc(1,0,1,0,1,1,1,1,'1,6'h31,'0,9);
    for (int k = 0; k < 3; k++) cyc(1,1,0,0,1,1,1,1,'1,'0,'0,5);
    // single-lane byte writes, each read back (R9)
    for (int i = 0; i < L; i++) begin
      cyc(1,0,1,0,1,1,0,1,~(L'(1) << i),6'h08,rnd_d(),9);
      cyc(1,0,1,0,1,1,1,1,'1,6'h08,'0,9);
    end
    // qualifier without lanes, lanes without qualifier: reads (R11)
    cyc(1,0,1,0,1,1,0,1,'1,6'h09,rnd_d(),11);
    cyc(1,0,1,0,1,1,1,1,'0,6'h09,rnd_d(),11);
    // global write overrides disabled lanes and qualifier (R10 R12)
    cyc(1,0,1,0,1,1,1,0,'1,6'h0a,rnd_d(),10);
    cyc(1,0,1,0,1,1,1,1,'1,6'h0a,'0,10);
    // hold in a burst, then continue (R8)
    cyc(1,0,1,0,1,0,1,1,'1,6'h15,'0,8);
    idle(2,8);
    cyc(1,1,0,0,1,0,1,1,'1,'0,'0,8);
    // deselect closes the burst; following steps do nothing (R3)
    cyc(1,0,1,1,1,1,1,1,'1,6'h16,'0,3);
    cyc(1,1,0,0,1,1,1,1,'1,'0,'0,3);
    cyc(1,0,1,0,1,1,1,1,'1,6'h17,'0,3);
    cyc(0,1,1,0,0,1,1,1,'1,6'h17,'0,3);
    cyc(1,1,0,0,1,1,1,0,'1,'0,rnd_d(),3);
    cyc(1,0,1,0,1,1,1,1,'1,6'h17,'0,3);
    // mixed random traffic in both orders (R5)
    for (int i = 0; i < 1500; i++) begin
      int r;
      r = $urandom % 16;
      cyc(!(r == 0), !(r inside {[1:4]}), ($urandom % 4 == 0), ($urandom % 12 == 0),
          ($urandom % 12 != 0), i[9], ($urandom % 2 == 1), ($urandom % 6 != 0),
          L'($urandom), A'($urandom), rnd_d(), 5);
    end
    // read back every word
    for (int i = 0; i < DEPTH; i++) cyc(1,0,1,0,1,1,1,1,'1,A'(i),'0,2);
    idle(3,8);
    repeat (3) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule